// File: doc/BRIEF.md
# Maskable Real-Time-Clock Alarm Matcher

This block holds the four alarm bytes of a real-time clock and compares them with the live timekeeping bytes. The four bytes are seconds, minutes, hours and a day/date byte. Each alarm byte carries a mask bit. A masked field always counts as matching, so the mask bits together set the alarm rate. That rate runs from once per second, with every field masked, up to once per matching day or date, with no field masked. The fourth alarm byte also carries a select bit. It chooses whether the low part of that byte is compared with the day-of-week counter or with the day-of-month counter.

The host writes and reads the alarm bytes through a small byte-wide register port. The surrounding timekeeper supplies the current BCD time bytes, an oscillator-run input and a one-second tick. The tick is raised in the cycle after the time bytes have been updated. The compare is evaluated only in a tick cycle and only while the oscillator runs. A full match sets a sticky alarm flag, which stays set until the host clears it.

Top module: `rtc_alarm_match`

## Requirements
- R1: While `rst` is high at a clock edge, all four alarm bytes become 00h and `alarm_flag` becomes 0.
- R2: `reg_addr` selects an alarm byte: 0 is seconds, 1 is minutes, 2 is hours, 3 is day/date. A write with `reg_wr_en` high stores all 8 bits of `reg_wdata` at the clock edge. `reg_rdata` shows the stored byte at `reg_addr` combinationally.
- R3: In alarm bytes 0 to 2, bit 7 is clear when the field is unmasked. Such a field matches only when its bits 6:0 equal bits 6:0 of the live seconds, minutes or hours byte. Bit 7 of the live byte is ignored.
- R4: An alarm byte with bit 7 set matches any live value.
- R5: In alarm byte 3, bit 6 selects the compare source: 1 means the live day-of-week byte and 0 means the live date byte. When bit 7 is clear, bits 5:0 must equal bits 5:0 of the selected byte. Bits 7:6 of the live bytes are ignored.
- R6: `alarm_flag` rises at the clock edge that ends a cycle in which `tick` and `osc_en` are both high and all four fields match.
- R7: With `osc_en` low, the flag is never set.
- R8: Without `tick`, the flag is never set, even if all fields match.
- R9: Once set, the flag holds until a cycle with `flag_clr` high, and it is 0 after that edge.
- R10: If a set condition and `flag_clr` occur in the same cycle, the flag is 1 after the edge.
- R11: With all four mask bits set, every tick taken while `osc_en` is high sets the flag.
- R12: A write in a tick cycle does not affect that cycle's compare, which uses the alarm bytes stored before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sec_i | input | 8 | Live seconds byte (BCD) |
| min_i | input | 8 | Live minutes byte (BCD) |
| hour_i | input | 8 | Live hours byte |
| dow_i | input | 8 | Live day-of-week byte |
| date_i | input | 8 | Live day-of-month byte (BCD) |
| reg_wr_en | input | 1 | Alarm byte write strobe |
| reg_addr | input | 2 | Alarm byte index |
| reg_wdata | input | 8 | Alarm byte write data |
| reg_rdata | output | 8 | Alarm byte read data |
| osc_en | input | 1 | Oscillator running; gates alarm setting |
| flag_clr | input | 1 | Clears the alarm flag |
| tick | input | 1 | One-second tick, high one cycle after the time update |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
The bench drives live bytes that have bit 7 set while they should still match. A design that compares all eight bits would miss those alarms. It flips the day/date select between a day-of-week that matches and a date that does not, and back the other way. A swapped select would raise the flag in the wrong case. It also puts a clear and a new match in the same cycle, which catches clear-wins priority. It writes an alarm byte in a tick cycle, which exposes a compare that reads the new value too early. It also runs ticks with the oscillator stopped and matches with no tick, where a missing gate shows up as an unwanted flag.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int unsigned ALM_DATA_W   = 8;
    localparam int unsigned ALM_FIELDS   = 4;
    localparam int unsigned ALM_DAY_IDX  = ALM_FIELDS - 1;
    localparam int unsigned ALM_ADDR_W   = $clog2(ALM_FIELDS);

    typedef logic [ALM_DATA_W-1:0] alm_byte_t;

    typedef enum logic [ALM_ADDR_W-1:0] {
        FLD_SEC  = 2'd0,
        FLD_MIN  = 2'd1,
        FLD_HOUR = 2'd2,
        FLD_DAY  = 2'd3
    } alm_field_e;

    // live timekeeping snapshot as presented by the clock core
    typedef struct packed {
        alm_byte_t sec;
        alm_byte_t min;
        alm_byte_t hour;
        alm_byte_t dow;
        alm_byte_t date;
    } rtc_now_t;

    // mask bit of any alarm byte is its top bit
    function automatic logic fld_masked(input alm_byte_t b);
        return b[ALM_DATA_W-1];
    endfunction

    // day/date selector sits just below the mask bit
    function automatic logic fld_day_sel(input alm_byte_t b);
        return b[ALM_DATA_W-2];
    endfunction

endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
#(
    parameter int unsigned NUM_REGS = ALM_FIELDS,
    parameter int unsigned DATA_W   = ALM_DATA_W,
    localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              rdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0] regs_o
);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else if (wr_en && (addr == ADDR_W'(g))) begin
                regs_q[g] <= wdata;
            end
        end
    end

    assign rdata  = regs_q[addr];
    assign regs_o = regs_q;

endmodule

// File: rtl/rtc_alarm_field_cmp.sv
module rtc_alarm_field_cmp
    import rtc_alarm_pkg::*;
#(
    parameter int unsigned DATA_W  = ALM_DATA_W,
    parameter bit          HAS_SEL = 1'b0,
    localparam int unsigned CMP_W  = HAS_SEL ? DATA_W - 2 : DATA_W - 1
) (
    input  logic [DATA_W-1:0] alm_byte,
    input  logic [DATA_W-1:0] cur_a,
    input  logic [DATA_W-1:0] cur_b,
    output logic              hit
);

    logic masked;
    assign masked = fld_masked(alm_byte);

    if (HAS_SEL) begin : g_sel
        logic [CMP_W-1:0] cur_pick;
        logic             unused_sel;
        // selector 1 picks source a (day of week), 0 picks source b (date)
        assign cur_pick   = fld_day_sel(alm_byte) ? cur_a[CMP_W-1:0] : cur_b[CMP_W-1:0];
        assign hit        = masked | (alm_byte[CMP_W-1:0] == cur_pick);
        assign unused_sel = ^{cur_a[DATA_W-1:CMP_W], cur_b[DATA_W-1:CMP_W]};
    end else begin : g_plain
        logic unused_plain;
        assign hit          = masked | (alm_byte[CMP_W-1:0] == cur_a[CMP_W-1:0]);
        assign unused_plain = ^{cur_a[DATA_W-1:CMP_W], cur_b};
    end

endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic osc_en,
    input  logic hit_all,
    input  logic clr,
    output logic flag
);

    logic set_now;
    logic flag_q;

    assign set_now = tick & osc_en & hit_all;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (set_now) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ALM_DATA_W-1:0] sec_i,
    input  logic [ALM_DATA_W-1:0] min_i,
    input  logic [ALM_DATA_W-1:0] hour_i,
    input  logic [ALM_DATA_W-1:0] dow_i,
    input  logic [ALM_DATA_W-1:0] date_i,
    input  logic                  reg_wr_en,
    input  logic [ALM_ADDR_W-1:0] reg_addr,
    input  logic [ALM_DATA_W-1:0] reg_wdata,
    output logic [ALM_DATA_W-1:0] reg_rdata,
    input  logic                  osc_en,
    input  logic                  flag_clr,
    input  logic                  tick,
    output logic                  alarm_flag
);

    rtc_now_t                            now;
    logic [ALM_FIELDS-1:0][ALM_DATA_W-1:0] alm_q;
    logic [ALM_FIELDS-1:0][ALM_DATA_W-1:0] live_a;
    logic [ALM_FIELDS-1:0][ALM_DATA_W-1:0] live_b;
    logic [ALM_FIELDS-1:0]                 fld_hit;
    logic                                  hit_all;

    assign now = '{sec: sec_i, min: min_i, hour: hour_i, dow: dow_i, date: date_i};

    always_comb begin
        live_a[FLD_SEC]  = now.sec;
        live_a[FLD_MIN]  = now.min;
        live_a[FLD_HOUR] = now.hour;
        live_a[FLD_DAY]  = now.dow;
        live_b           = live_a;
        live_b[FLD_DAY]  = now.date;
    end

    rtc_alarm_regs #(
        .NUM_REGS (ALM_FIELDS),
        .DATA_W   (ALM_DATA_W)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_wr_en),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .regs_o (alm_q)
    );

    for (genvar f = 0; f < ALM_FIELDS; f++) begin : g_fld
        rtc_alarm_field_cmp #(
            .DATA_W  (ALM_DATA_W),
            .HAS_SEL (f == ALM_DAY_IDX)
        ) u_cmp (
            .alm_byte (alm_q[f]),
            .cur_a    (live_a[f]),
            .cur_b    (live_b[f]),
            .hit      (fld_hit[f])
        );
    end

    assign hit_all = &fld_hit;

    rtc_alarm_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .osc_en  (osc_en),
        .hit_all (hit_all),
        .clr     (flag_clr),
        .flag    (alarm_flag)
    );

endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk
    import rtc_alarm_pkg::*;
(
    input logic                                  clk,
    input logic                                  rst,
    input logic                                  tick,
    input logic                                  osc_en,
    input logic                                  flag_clr,
    input logic                                  reg_wr_en,
    input logic [ALM_ADDR_W-1:0]                 reg_addr,
    input logic [ALM_DATA_W-1:0]                 reg_wdata,
    input logic                                  alarm_flag,
    input logic [ALM_FIELDS-1:0][ALM_DATA_W-1:0] alm_regs
);

    logic all_masked;
    assign all_masked = alm_regs[0][ALM_DATA_W-1] & alm_regs[1][ALM_DATA_W-1]
                      & alm_regs[2][ALM_DATA_W-1] & alm_regs[3][ALM_DATA_W-1];

    AST_RESET_FLAG_LOW: assert property (@(posedge clk) rst |=> !alarm_flag); // R1

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> alm_regs[$past(reg_addr)] == $past(reg_wdata)); // R2

    AST_NO_SET_OSC_OFF: assert property (@(posedge clk) disable iff (rst)
        (!osc_en && !alarm_flag) |=> !alarm_flag); // R7

    AST_NO_SET_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && !alarm_flag) |=> !alarm_flag); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag && !flag_clr) |=> alarm_flag); // R9

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !tick) |=> !alarm_flag); // R9

    AST_ALL_MASKED_FIRES: assert property (@(posedge clk) disable iff (rst)
        (tick && osc_en && all_masked) |=> alarm_flag); // R11

endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .osc_en     (osc_en),
    .flag_clr   (flag_clr),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .alarm_flag (alarm_flag),
    .alm_regs   (alm_q)
);

// File: tb/tb_rtc_alarm_match.sv
`timescale 1ns/1ps
module tb_rtc_alarm_match;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] sec_i = 8'h00, min_i = 8'h00, hour_i = 8'h00, dow_i = 8'h00, date_i = 8'h00;
    logic       reg_wr_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       osc_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       tick = 1'b0;
    logic       alarm_flag;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [7:0] m_alm [4];
    logic       m_flag;

    always #2.5 clk = ~clk;

    rtc_alarm_match dut (
        .clk(clk), .rst(rst),
        .sec_i(sec_i), .min_i(min_i), .hour_i(hour_i), .dow_i(dow_i), .date_i(date_i),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .osc_en(osc_en), .flag_clr(flag_clr), .tick(tick), .alarm_flag(alarm_flag)
    );

    function automatic bit model_match();
        bit ok = 1'b1;
        logic [7:0] live [3];
        live[0] = sec_i; live[1] = min_i; live[2] = hour_i;
        for (int i = 0; i < 3; i++)
            if (!m_alm[i][7] && (m_alm[i][6:0] != live[i][6:0])) ok = 1'b0;
        if (!m_alm[3][7]) begin
            if (m_alm[3][6]) begin
                if (m_alm[3][5:0] != dow_i[5:0]) ok = 1'b0;
            end else begin
                if (m_alm[3][5:0] != date_i[5:0]) ok = 1'b0;
            end
        end
        return ok;
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: predict, clock, compare
    task automatic cyc(input string tag);
        logic [7:0] n_alm [4];
        logic       n_flag;
        for (int i = 0; i < 4; i++) n_alm[i] = m_alm[i];
        n_flag = m_flag;
        if (rst) begin
            for (int i = 0; i < 4; i++) n_alm[i] = 8'h00;
            n_flag = 1'b0;
        end else begin
            if (tick && osc_en && model_match()) n_flag = 1'b1;
            else if (flag_clr)                   n_flag = 1'b0;
            if (reg_wr_en) n_alm[reg_addr] = reg_wdata;
        end
        @(posedge clk);
        #1;
        for (int i = 0; i < 4; i++) m_alm[i] = n_alm[i];
        m_flag = n_flag;
        check8({tag, " flag"}, {7'd0, alarm_flag}, {7'd0, m_flag});
        check8({tag, " rdata"}, reg_rdata, m_alm[reg_addr]);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        cyc(tag);
        reg_wr_en = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] dw, input logic [7:0] dt);
        sec_i = s; min_i = m; hour_i = h; dow_i = dw; date_i = dt;
    endtask

    task automatic pulse_tick(input string tag);
        tick = 1'b1;
        cyc(tag);
        tick = 1'b0;
    endtask

    task automatic clear_flag(input string tag);
        flag_clr = 1'b1;
        cyc(tag);
        flag_clr = 1'b0;
    endtask

    task automatic expect_flag(input logic e, input string tag);
        check8({tag, " explicit"}, {7'd0, alarm_flag}, {7'd0, e});
    endtask

    initial begin
        for (int i = 0; i < 4; i++) m_alm[i] = 8'h00;
        m_flag = 1'b0;
        repeat (3) cyc("R1 reset");
        rst = 1'b0;
        for (int a = 0; a < 4; a++) begin
            reg_addr = 2'(a);
            #1;
            check8("R1 reset byte", reg_rdata, 8'h00);
        end
        expect_flag(1'b0, "R1");

        // R2 register access, full 8 bits
        wr(2'd2, 8'hFF, "R2 write");
        reg_addr = 2'd2; #1;
        check8("R2 readback FF", reg_rdata, 8'hFF);
        wr(2'd0, 8'h15, "R2 sec");
        wr(2'd1, 8'h30, "R2 min");
        wr(2'd2, 8'h08, "R2 hour");
        wr(2'd3, 8'h12, "R2 daydate");
        reg_addr = 2'd3; #1;
        check8("R2 readback day", reg_rdata, 8'h12);

        // R3 / R6 match with live bit 7 set
        osc_en = 1'b1;
        set_time(8'h95, 8'hB0, 8'h88, 8'h03, 8'hD2);
        pulse_tick("R6 match");
        expect_flag(1'b1, "R3 R6");
        repeat (3) cyc("R9 hold");
        expect_flag(1'b1, "R9 sticky");
        clear_flag("R9 clear");
        expect_flag(1'b0, "R9 cleared");

        // R3 one field off
        set_time(8'h15, 8'h31, 8'h08, 8'h03, 8'h12);
        pulse_tick("R3 mismatch");
        expect_flag(1'b0, "R3 mismatch");

        // R4 mask minutes
        wr(2'd1, 8'hB0, "R4 mask");
        pulse_tick("R4 masked");
        expect_flag(1'b1, "R4 masked");
        clear_flag("R4 clear");

        // R7 oscillator off
        osc_en = 1'b0;
        pulse_tick("R7 osc off");
        expect_flag(1'b0, "R7");
        osc_en = 1'b1;

        // R8 no tick
        repeat (3) cyc("R8 no tick");
        expect_flag(1'b0, "R8");

        // R5 day-of-week select
        wr(2'd3, 8'h45, "R5 day sel");
        set_time(8'h15, 8'h22, 8'h08, 8'hC5, 8'h12);
        pulse_tick("R5 dow match");
        expect_flag(1'b1, "R5 dow");
        clear_flag("R5 clear");
        set_time(8'h15, 8'h22, 8'h08, 8'h04, 8'h05);
        pulse_tick("R5 dow miss");
        expect_flag(1'b0, "R5 dow miss");
        // date select
        wr(2'd3, 8'h12, "R5 date sel");
        set_time(8'h15, 8'h22, 8'h08, 8'h12, 8'h13);
        pulse_tick("R5 date miss");
        expect_flag(1'b0, "R5 date miss");
        set_time(8'h15, 8'h22, 8'h08, 8'h07, 8'h52);
        pulse_tick("R5 date match");
        expect_flag(1'b1, "R5 date");

        // R10 set beats clear
        flag_clr = 1'b1; tick = 1'b1;
        cyc("R10 both");
        flag_clr = 1'b0; tick = 1'b0;
        expect_flag(1'b1, "R10");
        clear_flag("R10 clear");

        // R11 all masked
        for (int a = 0; a < 4; a++) wr(2'(a), 8'h80, "R11 mask all");
        for (int k = 0; k < 5; k++) begin
            set_time(8'(k * 7), 8'(k * 3 + 1), 8'(k + 2), 8'(k), 8'(k * 5));
            pulse_tick("R11 tick");
            expect_flag(1'b1, "R11");
            clear_flag("R11 clear");
            expect_flag(1'b0, "R11 cleared");
        end

        // R12 write in tick cycle uses old value
        wr(2'd0, 8'h15, "R12 setup");
        set_time(8'h15, 8'h00, 8'h00, 8'h00, 8'h00);
        reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h16; tick = 1'b1;
        cyc("R12 write+tick");
        reg_wr_en = 1'b0; tick = 1'b0;
        expect_flag(1'b1, "R12 old value");
        clear_flag("R12 clear");
        pulse_tick("R12 new value");
        expect_flag(1'b0, "R12 new value");

        // R1 reset mid-run
        wr(2'd2, 8'h80, "R1 pre");
        pulse_tick("R1 pre tick");
        rst = 1'b1;
        cyc("R1 reset again");
        rst = 1'b0;
        expect_flag(1'b0, "R1 again");
        reg_addr = 2'd2; #1;
        check8("R1 byte again", reg_rdata, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule